// File: doc/BRIEF.md
# Up/Down Event Counter with Status Flags

This block counts events arriving on two level inputs, one for counting up and one for counting down. It counts only a low-to-high change of an input, not the time the input stays high. So a condition that stays high for many cycles adds or removes exactly one count. The accumulator is a signed two's-complement value. It stops at its most positive and most negative values instead of wrapping round.

A signed preset is compared with the accumulator at all times. The done flag shows that the count has reached or passed the preset. Two enable flags repeat the level of each input, delayed by one register. A clear input holds the count at zero for as long as it is asserted. A synchronous active-low reset returns the whole block to its idle state.

Top module: `evt_updown_counter`

## Requirements
- R1: A 0-to-1 change of `up_in` between two consecutive clock edges increases `count` by one at the second edge. No increase happens when `clr` is high, when `dn_in` rises at the same edge, or when `count` is already at its maximum.
- R2: A 0-to-1 change of `dn_in` decreases `count` by one at that edge. The same three exceptions apply: `clr` high, `up_in` rising at the same edge, or `count` already at its minimum.
- R3: When both inputs rise at the same edge, `count` is unchanged.
- R4: With no rising input, `count` holds its value. This covers an input that stays high, an input that stays low, and an input going from high to low.
- R5: `count` saturates. Further up events at +(2^(W-1))-1 leave it there, and further down events at -(2^(W-1)) leave it there.
- R6: `count` is 0 after every edge at which `clr` is high, and `clr` takes priority over any event at that edge. An input that rises while `clr` is high is not counted later.
- R7: `done` is high exactly when `count` >= `preset` in a signed comparison. It follows changes of `preset` without a clock edge.
- R8: `up_en` and `dn_en` equal the levels that `up_in` and `dn_in` had at the latest clock edge.
- R9: An edge with `rst_n` low sets `count` to 0 and `up_en` and `dn_en` to 0. An input that is high at the first edge after reset counts as a rising change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_in | input | 1 | Up-count condition level |
| dn_in | input | 1 | Down-count condition level |
| clr | input | 1 | Clears the accumulator while high |
| preset | input | W | Signed compare value |
| count | output | W | Signed accumulator |
| up_en | output | 1 | Registered level of `up_in` |
| dn_en | output | 1 | Registered level of `dn_in` |
| done | output | 1 | `count` >= `preset` (signed) |

## Verification
Every change on `up_in`, `dn_in`, `clr` and `rst_n` shows up on `count`, `up_en` and `dn_en` one clock edge later. `done` depends only on `count` and `preset` through combinational logic, so it is valid in the same cycle as `count`, and immediately after any change of `preset`. The bench drives its inputs at the falling edge and advances its reference model once per rising edge. It compares all four outputs at the next falling edge, which is exactly one rising edge after the stimulus.

// File: rtl/evt_cnt_pkg.sv
// Package: shared channel indices for the event counter.
// Assumes two channels only: one up, one down.
package evt_cnt_pkg;
    localparam int CH_UP  = 0;
    localparam int CH_DN  = 1;
    localparam int NUM_CH = 2;
endpackage

// File: rtl/evt_rise_detect.sv
// Rising-change detector: registers each level input and flags a
// 0-to-1 change between consecutive clock edges.
// Assumes the inputs are synchronous to clk.
module evt_rise_detect #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] lvl_q,
    output logic [N-1:0] rise
);
    for (genvar i = 0; i < N; i++) begin : g_ch
        // Holds the level seen at the previous edge; cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) lvl_q[i] <= 1'b0;
            else        lvl_q[i] <= lvl[i];
        end

        // A change is flagged when the input is high now and was low before.
        always_comb rise[i] = lvl[i] & ~lvl_q[i];

        // The stored level follows the input one edge later (R8)
        assert_level_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (lvl_q[i] == $past(lvl[i])));
    end
endmodule

// File: rtl/evt_sat_acc.sv
// Saturating signed accumulator: +1 on inc, -1 on dec, and no change
// when both arrive together. clr forces zero and takes priority.
// Assumes inc and dec are single-cycle event strobes.
module evt_sat_acc #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                inc,
    input  logic                dec,
    output logic signed [W-1:0] acc
);
    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic signed [W-1:0] ZERO = '0;

    logic signed [W-1:0] acc_nxt;

    // Chooses the next value: clear first, then a single step with saturation.
    always_comb begin
        acc_nxt = acc;
        if (clr)                                 acc_nxt = ZERO;
        else if (inc && !dec && (acc != MAXV))   acc_nxt = acc + ONE;
        else if (dec && !inc && (acc != MINV))   acc_nxt = acc - ONE;
    end

    // Stores the accumulator; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) acc <= ZERO;
        else        acc <= acc_nxt;
    end

    // An up event below the maximum adds one (R1)
    assert_up_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && !dec && acc != MAXV) |=> (acc == $past(acc) + ONE));
    // A down event above the minimum subtracts one (R2)
    assert_dn_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && dec && !inc && acc != MINV) |=> (acc == $past(acc) - ONE));
    // Simultaneous events, or none, leave the value alone (R3, R4)
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (inc == dec)) |=> $stable(acc));
    // The value sticks at the upper limit (R5)
    assert_sat_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && acc == MAXV && !dec) |=> (acc == MAXV));
    // The value sticks at the lower limit (R5)
    assert_sat_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && acc == MINV && !inc) |=> (acc == MINV));
    // Clear wins over any event (R6)
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == ZERO));
endmodule

// File: rtl/evt_ge_cmp.sv
// Signed greater-or-equal comparator between the accumulator and the preset.
// Purely combinational.
module evt_ge_cmp #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic                ge
);
    // Signed compare of the two operands.
    always_comb ge = (a >= b);
endmodule

// File: rtl/evt_updown_counter.sv
// Top: up/down event counter. The level inputs pass through a
// rising-change detector and drive a saturating accumulator, and a
// comparator produces the done flag.
// Assumes all inputs are synchronous to clk and rst_n is active low.
module evt_updown_counter #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                up_in,
    input  logic                dn_in,
    input  logic                clr,
    input  logic signed [W-1:0] preset,
    output logic signed [W-1:0] count,
    output logic                up_en,
    output logic                dn_en,
    output logic                done
);
    import evt_cnt_pkg::*;

    logic [NUM_CH-1:0] lvl, lvl_q, rise;

    // Packs the two condition inputs into the channel vector.
    always_comb begin
        lvl[CH_UP] = up_in;
        lvl[CH_DN] = dn_in;
    end

    evt_rise_detect #(.N(NUM_CH)) u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl),
        .lvl_q (lvl_q),
        .rise  (rise)
    );

    evt_sat_acc #(.W(W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (rise[CH_UP]),
        .dec   (rise[CH_DN]),
        .acc   (count)
    );

    evt_ge_cmp #(.W(W)) u_cmp (
        .a  (count),
        .b  (preset),
        .ge (done)
    );

    // Brings the registered levels out as the enable flags.
    always_comb begin
        up_en = lvl_q[CH_UP];
        dn_en = lvl_q[CH_DN];
    end

    // After a reset edge both enable flags are low (R9)
    assert_reset_flags_R9: assert property (@(posedge clk)
        !rst_n |=> (!up_en && !dn_en));
endmodule

// File: tb/evt_updown_counter_bench.sv
module evt_updown_counter_bench;
    localparam int W = 8;
    localparam int MAXI = 127;
    localparam int MINI = -128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_in = 1'b0, dn_in = 1'b0, clr = 1'b0;
    logic signed [W-1:0] preset = '0;
    logic signed [W-1:0] count;
    logic up_en, dn_en, done;

    int errors = 0;
    int checks = 0;
    int m_cnt = 0;
    bit m_pu = 0, m_pd = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    evt_updown_counter #(.W(W)) u_evt_updown_counter (
        .clk(clk), .rst_n(rst_n), .up_in(up_in), .dn_in(dn_in), .clr(clr),
        .preset(preset), .count(count), .up_en(up_en), .dn_en(dn_en), .done(done)
    );

    function automatic int next_count(int c, bit ru, bit rd, bit cl);
        if (cl) return 0;
        if (ru && !rd) return (c == MAXI) ? c : c + 1;
        if (rd && !ru) return (c == MINI) ? c : c - 1;
        return c;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, int'(count), m_cnt);
        chk("R7 done", int'(done), int'(m_cnt >= int'(preset)));
        chk("R8 up_en", int'(up_en), int'(m_pu));
        chk("R8 dn_en", int'(dn_en), int'(m_pd));
    endtask

    // Called at a falling edge: drive, advance the model by one rising edge, check.
    task automatic cyc(bit u, bit d, bit c, string tag);
        up_in = u; dn_in = d; clr = c;
        if (!rst_n) begin
            m_cnt = 0; m_pu = 0; m_pd = 0;
        end else begin
            m_cnt = next_count(m_cnt, u & ~m_pu, d & ~m_pd, c);
            m_pu = u; m_pd = d;
        end
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic pulse_up(string tag);
        cyc(1, 0, 0, tag);
        cyc(0, 0, 0, tag);
    endtask

    task automatic pulse_dn(string tag);
        cyc(0, 1, 0, tag);
        cyc(0, 0, 0, tag);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        cyc(1, 1, 0, "R9 reset");
        cyc(0, 0, 0, "R9 reset");
        rst_n = 1'b1;
        preset = 8'sd3;
        // R1 counting and the done threshold (R7)
        for (int i = 0; i < 4; i++) pulse_up("R1 up pulse");
        // R4: a level held high counts once
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, "R4 held high");
        cyc(0, 0, 0, "R4 falling");
        // R2 down events below the preset
        for (int i = 0; i < 3; i++) pulse_dn("R2 down pulse");
        // R3 simultaneous rises cancel
        cyc(1, 1, 0, "R3 both rise");
        cyc(0, 0, 0, "R3 both fall");
        // R7 negative preset, checked with no clock edge in between
        preset = -8'sd2;
        #1 chk("R7 preset change", int'(done), int'(m_cnt >= -2));
        // R6: clear wins, and a rise during clear is not counted later
        cyc(1, 0, 1, "R6 clear with rise");
        cyc(1, 0, 0, "R6 no late count");
        cyc(0, 0, 0, "R6 idle");
        // R5 saturation at both limits
        for (int i = 0; i < 135; i++) pulse_up("R5 upper limit");
        chk("R5 at max", int'(count), MAXI);
        for (int i = 0; i < 260; i++) pulse_dn("R5 lower limit");
        chk("R5 at min", int'(count), MINI);
        // R9: a mid-run reset, then an input high at the first edge counts
        rst_n = 1'b0;
        cyc(1, 1, 0, "R9 reset mid");
        rst_n = 1'b1;
        cyc(1, 0, 0, "R9 first edge rise");
        // Random mix; each step checks R1 R2 R3 R4 R6
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 49) == 0) preset = W'($urandom);
            cyc(1'($urandom), 1'($urandom), ($urandom_range(0, 29) == 0),
                "R1 R2 R3 R4 R6 random");
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule